// File: doc/BRIEF.md
# Serial Configuration Loader for a Numerically Controlled Oscillator

This block is the write-only configuration port of a numerically controlled oscillator. A host shifts 16-bit command words in over three wires: a serial clock, a serial data line and an active-low frame strobe. Each word carries an opcode, a register address and a data byte. The block keeps the oscillator's tuning words, phase offsets and select controls in registers clocked by the serial clock. Every completed word is handed to the master clock domain by toggling a strobe.

A 16-bit register half is filled in two writes. A "park" word stores a byte in a holding register. A "commit" word then writes its own byte together with the parked byte into the addressed half in one update. Each tuning word is split into a low half and a high half, and each half can be written on its own. Phase offsets keep only the low bits of the assembled value.

A mode word sets a synchronisation flag and a source flag. A select word sets register copies of the frequency and phase selects. The source flag chooses whether the selects presented to the oscillator come from external pins or from those register bits.

Top module: `sdl_serial_loader`

## Requirements
- R1: While rst_n is low, and until the first accepted word, tune_o and phase_o read zero, sync_mode_o and src_sel_o read 0, and the register copies of the selects are 0.
- R2: A word is formed from the first 16 sdata bits sampled on falling sclk edges while fsync_n is low, most significant bit first. It is acted on at the 16th bit. Further bits in the same frame are ignored until fsync_n returns high.
- R3: A frame that ends (fsync_n high) before its 16th bit changes nothing.
- R4: Opcode 4'h0 in bits 15:12 stores data bits 7:0 in the park register and changes no output.
- R5: Opcode 4'h1 writes {data byte, parked byte} (own byte in bits 15:8) to the half addressed by bits 11:8. The parked byte is kept for later commits.
- R6: Address 2k writes bits 15:0 of tuning word k and address 2k+1 writes bits 31:16. Each half changes alone. tune_o holds word k in bits 32k+31:32k.
- R7: Addresses 4 to 7 write phase offsets 0 to 3. Each keeps the low 12 bits of the assembled value; the upper 4 bits are dropped. phase_o holds offset p in bits 12p+11:12p.
- R8: Commits to addresses 8 to 15, and opcodes 4'h2 to 4'h7, change no output.
- R9: Any opcode 4'b10xx loads sync_mode_o from word bit 13 and src_sel_o from word bit 12.
- R10: Any opcode 4'b11xx loads the register frequency select from data bit 4 and the register phase select from data bits 1:0.
- R11: With src_sel_o at 0, freq_sel_o and phase_sel_o follow the pins after the pin synchroniser. With src_sel_o at 1, they show the register selects and pin changes have no effect.
- R12: Configuration outputs change only when a completed word crosses into the mclk domain, a few mclk cycles after its 16th bit. They hold their old value at the 16th falling sclk edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock of the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| fsync_n | input | 1 | Active-low frame strobe |
| sdata | input | 1 | Serial data, MSB first |
| fsel_pin_i | input | FSEL_W | External frequency select pin(s) |
| psel_pin_i | input | PSEL_W | External phase select pins |
| tune_o | output | 32*NUM_FREQ | Tuning words, word k at bits 32k+31:32k |
| phase_o | output | PHASE_W*NUM_PHASE | Phase offsets, offset p at bits PHASE_W*p upward |
| sync_mode_o | output | 1 | Synchronisation mode flag |
| src_sel_o | output | 1 | 0: selects from pins, 1: from registers |
| freq_sel_o | output | FSEL_W | Frequency select presented to the oscillator |
| phase_sel_o | output | PSEL_W | Phase select presented to the oscillator |

## Verification
The hardest conditions to reach from the ports are frames with the wrong length. One kind is cut off after a few bits, where the bit count must be thrown away. The other kind overruns past 16 bits, where the trailing bits must not shift the word. The stimulus reaches both by sending frames of random length, mostly 16 bits but sometimes shorter or longer, mixed with random park, commit, mode and select words. A directed probe samples the outputs just after the 16th falling edge to show that they still hold their old values. Further directed sequences switch the select source while the pins move.

// File: rtl/sdl_pkg.sv
`timescale 1ns/1ps
package sdl_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;
   localparam int ADDR_W = 4;

   typedef struct packed {
      logic [3:0]        op;
      logic [ADDR_W-1:0] addr;
      logic [BYTE_W-1:0] dat;
   } sdl_word_t;

   localparam logic [3:0] OP_PARK   = 4'h0;
   localparam logic [3:0] OP_COMMIT = 4'h1;
   localparam logic [1:0] OP_MODE   = 2'b10;
   localparam logic [1:0] OP_SEL    = 2'b11;
   localparam int         FSEL_LSB  = 4;
endpackage

// File: rtl/sdl_frame_rx.sv
`timescale 1ns/1ps
module sdl_frame_rx
   import sdl_pkg::*;
(
   input  logic      sclk,
   input  logic      rst_n,
   input  logic      fsync_n,
   input  logic      sdata,
   output logic      fire_o,
   output sdl_word_t word_o
);
   localparam int CNT_W = $clog2(WORD_W + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-2:0] sh_q;
   logic              frm_clr;

   // frame strobe high clears the partial word asynchronously
   assign frm_clr = fsync_n | ~rst_n;

   always_ff @(negedge sclk or posedge frm_clr) begin
      if (frm_clr) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (cnt_q < CNT_W'(WORD_W)) begin
         sh_q  <= {sh_q[WORD_W-3:0], sdata};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign fire_o = ~fsync_n & (cnt_q == CNT_W'(WORD_W - 1));
   assign word_o = {sh_q, sdata};
endmodule

// File: rtl/sdl_reg_bank.sv
`timescale 1ns/1ps
module sdl_reg_bank
   import sdl_pkg::*;
#(
   parameter int NUM_FREQ  = 2,
   parameter int NUM_PHASE = 4,
   parameter int PHASE_W   = 12,
   parameter int FSEL_W    = 1,
   parameter int PSEL_W    = 2
) (
   input  logic                         sclk,
   input  logic                         rst_n,
   input  logic                         fire_i,
   input  sdl_word_t                    word_i,
   output logic [2*NUM_FREQ*HALF_W-1:0] tw_o,
   output logic [NUM_PHASE*PHASE_W-1:0] ph_o,
   output logic                         sync_o,
   output logic                         src_o,
   output logic [FSEL_W-1:0]            fsel_o,
   output logic [PSEL_W-1:0]            psel_o,
   output logic                         tgl_o
);
   localparam int NHALF = 2 * NUM_FREQ;

   logic [BYTE_W-1:0] park_q;
   logic [HALF_W-1:0] commit_val;
   logic              is_park, is_commit, is_mode, is_sel;

   assign is_park    = fire_i && (word_i.op == OP_PARK);
   assign is_commit  = fire_i && (word_i.op == OP_COMMIT);
   assign is_mode    = fire_i && (word_i.op[3:2] == OP_MODE);
   assign is_sel     = fire_i && (word_i.op[3:2] == OP_SEL);
   assign commit_val = {word_i.dat, park_q};

   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n)       park_q <= '0;
      else if (is_park) park_q <= word_i.dat;
   end

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      logic [HALF_W-1:0] q;
      always_ff @(negedge sclk or negedge rst_n) begin
         if (!rst_n)                                         q <= '0;
         else if (is_commit && word_i.addr == ADDR_W'(h))    q <= commit_val;
      end
      assign tw_o[h*HALF_W +: HALF_W] = q;
   end

   for (genvar p = 0; p < NUM_PHASE; p++) begin : g_phase
      logic [PHASE_W-1:0] q;
      always_ff @(negedge sclk or negedge rst_n) begin
         if (!rst_n)                                           q <= '0;
         else if (is_commit && word_i.addr == ADDR_W'(NHALF + p)) q <= commit_val[PHASE_W-1:0];
      end
      assign ph_o[p*PHASE_W +: PHASE_W] = q;
   end

   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         sync_o <= 1'b0;
         src_o  <= 1'b0;
      end else if (is_mode) begin
         sync_o <= word_i.op[1];
         src_o  <= word_i.op[0];
      end
   end

   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         fsel_o <= '0;
         psel_o <= '0;
      end else if (is_sel) begin
         fsel_o <= word_i.dat[FSEL_LSB +: FSEL_W];
         psel_o <= word_i.dat[PSEL_W-1:0];
      end
   end

   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n)      tgl_o <= 1'b0;
      else if (fire_i) tgl_o <= ~tgl_o;
   end
endmodule

// File: rtl/sdl_cdc_capture.sv
`timescale 1ns/1ps
module sdl_cdc_capture #(
   parameter int TW_W        = 64,
   parameter int PH_W        = 48,
   parameter int FSEL_W      = 1,
   parameter int PSEL_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_SYNC    = 1'b1
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              tgl_i,
   input  logic [TW_W-1:0]   tw_i,
   input  logic [PH_W-1:0]   ph_i,
   input  logic              sync_i,
   input  logic              src_i,
   input  logic [FSEL_W-1:0] fsel_r_i,
   input  logic [PSEL_W-1:0] psel_r_i,
   input  logic [FSEL_W-1:0] fsel_pin_i,
   input  logic [PSEL_W-1:0] psel_pin_i,
   output logic [TW_W-1:0]   tw_o,
   output logic [PH_W-1:0]   ph_o,
   output logic              sync_o,
   output logic              src_o,
   output logic [FSEL_W-1:0] fsel_o,
   output logic [PSEL_W-1:0] psel_o,
   output logic              upd_o,
   output logic [FSEL_W-1:0] fpin_s_o,
   output logic [PSEL_W-1:0] ppin_s_o
);
   logic [SYNC_STAGES-1:0] tchain;
   logic                   tseen;
   logic [FSEL_W-1:0]      rfsel_q;
   logic [PSEL_W-1:0]      rpsel_q;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         tchain <= '0;
         tseen  <= 1'b0;
      end else begin
         tchain <= {tchain[SYNC_STAGES-2:0], tgl_i};
         tseen  <= tchain[SYNC_STAGES-1];
      end
   end

   assign upd_o = tchain[SYNC_STAGES-1] ^ tseen;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         tw_o    <= '0;
         ph_o    <= '0;
         sync_o  <= 1'b0;
         src_o   <= 1'b0;
         rfsel_q <= '0;
         rpsel_q <= '0;
      end else if (upd_o) begin
         tw_o    <= tw_i;
         ph_o    <= ph_i;
         sync_o  <= sync_i;
         src_o   <= src_i;
         rfsel_q <= fsel_r_i;
         rpsel_q <= psel_r_i;
      end
   end

   if (PIN_SYNC) begin : g_pin_sync
      logic [FSEL_W-1:0] fch [SYNC_STAGES];
      logic [PSEL_W-1:0] pch [SYNC_STAGES];
      always_ff @(posedge mclk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
               fch[i] <= '0;
               pch[i] <= '0;
            end
         end else begin
            fch[0] <= fsel_pin_i;
            pch[0] <= psel_pin_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               fch[i] <= fch[i-1];
               pch[i] <= pch[i-1];
            end
         end
      end
      assign fpin_s_o = fch[SYNC_STAGES-1];
      assign ppin_s_o = pch[SYNC_STAGES-1];
   end else begin : g_pin_raw
      assign fpin_s_o = fsel_pin_i;
      assign ppin_s_o = psel_pin_i;
   end

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         fsel_o <= '0;
         psel_o <= '0;
      end else begin
         fsel_o <= src_o ? rfsel_q : fpin_s_o;
         psel_o <= src_o ? rpsel_q : ppin_s_o;
      end
   end
endmodule

// File: rtl/sdl_serial_loader.sv
`timescale 1ns/1ps
module sdl_serial_loader
   import sdl_pkg::*;
#(
   parameter int NUM_FREQ    = 2,
   parameter int NUM_PHASE   = 4,
   parameter int PHASE_W     = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_SYNC    = 1'b1,
   parameter int FSEL_W      = (NUM_FREQ > 1) ? $clog2(NUM_FREQ) : 1,
   parameter int PSEL_W      = (NUM_PHASE > 1) ? $clog2(NUM_PHASE) : 1
) (
   input  logic                         mclk,
   input  logic                         rst_n,
   input  logic                         sclk,
   input  logic                         fsync_n,
   input  logic                         sdata,
   input  logic [FSEL_W-1:0]            fsel_pin_i,
   input  logic [PSEL_W-1:0]            psel_pin_i,
   output logic [NUM_FREQ*32-1:0]       tune_o,
   output logic [NUM_PHASE*PHASE_W-1:0] phase_o,
   output logic                         sync_mode_o,
   output logic                         src_sel_o,
   output logic [FSEL_W-1:0]            freq_sel_o,
   output logic [PSEL_W-1:0]            phase_sel_o
);
   localparam int TW_W  = 2 * NUM_FREQ * HALF_W;
   localparam int PH_W  = NUM_PHASE * PHASE_W;
   localparam int NREG  = 2 * NUM_FREQ + NUM_PHASE;

   if (NUM_FREQ < 1 || NUM_PHASE < 1 || NREG > (1 << ADDR_W)) begin : g_bad_map
      $error("register count does not fit the address field");
   end
   if (PHASE_W < 1 || PHASE_W > HALF_W) begin : g_bad_phase
      $error("phase width must lie in 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages required");
   end
   if (FSEL_W > BYTE_W - FSEL_LSB || PSEL_W > FSEL_LSB) begin : g_bad_sel
      $error("select widths exceed their data-byte fields");
   end

   logic              rx_fire;
   sdl_word_t         rx_word;
   logic [TW_W-1:0]   bank_tw;
   logic [PH_W-1:0]   bank_ph;
   logic              bank_sync, bank_src, bank_tgl;
   logic [FSEL_W-1:0] bank_fsel, fpin_s;
   logic [PSEL_W-1:0] bank_psel, ppin_s;
   logic              cap_upd;

   sdl_frame_rx u_rx (
      .sclk    (sclk),
      .rst_n   (rst_n),
      .fsync_n (fsync_n),
      .sdata   (sdata),
      .fire_o  (rx_fire),
      .word_o  (rx_word)
   );

   sdl_reg_bank #(
      .NUM_FREQ  (NUM_FREQ),
      .NUM_PHASE (NUM_PHASE),
      .PHASE_W   (PHASE_W),
      .FSEL_W    (FSEL_W),
      .PSEL_W    (PSEL_W)
   ) u_bank (
      .sclk   (sclk),
      .rst_n  (rst_n),
      .fire_i (rx_fire),
      .word_i (rx_word),
      .tw_o   (bank_tw),
      .ph_o   (bank_ph),
      .sync_o (bank_sync),
      .src_o  (bank_src),
      .fsel_o (bank_fsel),
      .psel_o (bank_psel),
      .tgl_o  (bank_tgl)
   );

   sdl_cdc_capture #(
      .TW_W        (TW_W),
      .PH_W        (PH_W),
      .FSEL_W      (FSEL_W),
      .PSEL_W      (PSEL_W),
      .SYNC_STAGES (SYNC_STAGES),
      .PIN_SYNC    (PIN_SYNC)
   ) u_cap (
      .mclk       (mclk),
      .rst_n      (rst_n),
      .tgl_i      (bank_tgl),
      .tw_i       (bank_tw),
      .ph_i       (bank_ph),
      .sync_i     (bank_sync),
      .src_i      (bank_src),
      .fsel_r_i   (bank_fsel),
      .psel_r_i   (bank_psel),
      .fsel_pin_i (fsel_pin_i),
      .psel_pin_i (psel_pin_i),
      .tw_o       (tune_o),
      .ph_o       (phase_o),
      .sync_o     (sync_mode_o),
      .src_o      (src_sel_o),
      .fsel_o     (freq_sel_o),
      .psel_o     (phase_sel_o),
      .upd_o      (cap_upd),
      .fpin_s_o   (fpin_s),
      .ppin_s_o   (ppin_s)
   );
endmodule

// File: rtl/sdl_serial_loader_chk.sv
`timescale 1ns/1ps
module sdl_serial_loader_chk #(
   parameter int TW_W   = 64,
   parameter int PH_W   = 48,
   parameter int FSEL_W = 1,
   parameter int PSEL_W = 2
) (
   input logic              mclk,
   input logic              rst_n,
   input logic              upd,
   input logic [TW_W-1:0]   tune_o,
   input logic [PH_W-1:0]   phase_o,
   input logic              sync_mode_o,
   input logic              src_sel_o,
   input logic [FSEL_W-1:0] freq_sel_o,
   input logic [PSEL_W-1:0] phase_sel_o,
   input logic [FSEL_W-1:0] fpin_s,
   input logic [PSEL_W-1:0] ppin_s
);
   // R12
   tune_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !upd |=> $stable(tune_o));

   // R12
   phase_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !upd |=> $stable(phase_o));

   // R9
   mode_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !upd |=> ($stable(sync_mode_o) && $stable(src_sel_o)));

   // R11
   pin_freq_follow_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !src_sel_o |=> (freq_sel_o == $past(fpin_s)));

   // R11
   pin_phase_follow_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !src_sel_o |=> (phase_sel_o == $past(ppin_s)));

   // R11
   reg_sel_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      (src_sel_o && $past(src_sel_o) && !upd && !$past(upd))
      |=> ($stable(freq_sel_o) && $stable(phase_sel_o)));
endmodule

bind sdl_serial_loader sdl_serial_loader_chk #(
   .TW_W   (NUM_FREQ * 32),
   .PH_W   (NUM_PHASE * PHASE_W),
   .FSEL_W (FSEL_W),
   .PSEL_W (PSEL_W)
) u_chk (
   .mclk        (mclk),
   .rst_n       (rst_n),
   .upd         (cap_upd),
   .tune_o      (tune_o),
   .phase_o     (phase_o),
   .sync_mode_o (sync_mode_o),
   .src_sel_o   (src_sel_o),
   .freq_sel_o  (freq_sel_o),
   .phase_sel_o (phase_sel_o),
   .fpin_s      (fpin_s),
   .ppin_s      (ppin_s)
);

// File: tb/tb_sdl_serial_loader.sv
`timescale 1ns/1ps
module tb_sdl_serial_loader;
   logic        mclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        fsync_n = 1'b1;
   logic        sdata = 1'b0;
   logic [0:0]  fpin = '0;
   logic [1:0]  ppin = '0;
   logic [63:0] tune_o;
   logic [47:0] phase_o;
   logic        sync_mode_o, src_sel_o;
   logic [0:0]  freq_sel_o;
   logic [1:0]  phase_sel_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 mclk = ~mclk;

   sdl_serial_loader dut (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .sclk        (sclk),
      .fsync_n     (fsync_n),
      .sdata       (sdata),
      .fsel_pin_i  (fpin),
      .psel_pin_i  (ppin),
      .tune_o      (tune_o),
      .phase_o     (phase_o),
      .sync_mode_o (sync_mode_o),
      .src_sel_o   (src_sel_o),
      .freq_sel_o  (freq_sel_o),
      .phase_sel_o (phase_sel_o)
   );

   // reference model
   logic [15:0] m_half [4];
   logic [11:0] m_ph   [4];
   logic [7:0]  m_park;
   logic        m_sync, m_src;
   logic [0:0]  m_fsel;
   logic [1:0]  m_psel;

   function automatic void model_reset();
      for (int i = 0; i < 4; i++) begin
         m_half[i] = '0;
         m_ph[i]   = '0;
      end
      m_park = '0; m_sync = 1'b0; m_src = 1'b0; m_fsel = '0; m_psel = '0;
   endfunction

   function automatic void model_word(input logic [15:0] w);
      logic [15:0] v;
      v = {w[7:0], m_park};
      if (w[15:12] == 4'h0) m_park = w[7:0];
      else if (w[15:12] == 4'h1) begin
         if (w[11:8] < 4)       m_half[w[9:8]] = v;
         else if (w[11:8] < 8)  m_ph[w[9:8]]   = v[11:0];
      end else if (w[15:14] == 2'b10) begin
         m_sync = w[13];
         m_src  = w[12];
      end else if (w[15:14] == 2'b11) begin
         m_fsel = w[4];
         m_psel = w[1:0];
      end
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, tune_o, {m_half[3], m_half[2], m_half[1], m_half[0]});
      chk(tag, 64'(phase_o), 64'({m_ph[3], m_ph[2], m_ph[1], m_ph[0]}));
      chk(tag, 64'({sync_mode_o, src_sel_o}), 64'({m_sync, m_src}));
      chk(tag, 64'(freq_sel_o),  64'(m_src ? m_fsel : fpin));
      chk(tag, 64'(phase_sel_o), 64'(m_src ? m_psel : ppin));
   endtask

   // shifts nbits; when probe is set, outputs are compared with the
   // pre-word expectation right after the 16th falling edge
   task automatic send(input logic [15:0] w, input int nbits, input bit probe);
      fsync_n = 1'b0;
      #20;
      for (int i = 0; i < nbits; i++) begin
         sdata = (i < 16) ? w[15-i] : 1'($urandom);
         #20 sclk = 1'b0;
         if (probe && i == 15) begin
            #2 check_all("R12");
         end
         #20 sclk = 1'b1;
      end
      #10 fsync_n = 1'b1;
      #20;
      if (nbits >= 16) model_word(w);
   endtask

   task automatic settle();
      repeat (8) @(posedge mclk);
      @(negedge mclk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (4) @(posedge mclk);
      @(negedge mclk);
      check_all("R1");
      rst_n = 1'b1;
      settle();
      check_all("R1");

      // R4: park alone changes nothing
      send(16'h00CD, 16, 1'b0); settle(); check_all("R4");
      // R5 R6: commit high half of word 0, outputs hold at the last edge (R12)
      send(16'h11AB, 16, 1'b1); settle(); check_all("R5");
      chk("R6", 64'(tune_o[31:16]), 64'h00AB_CD00 >> 8);
      // R5: parked byte reused, low half written alone
      send(16'h1012, 16, 1'b0); settle(); check_all("R5");
      chk("R6", 64'(tune_o[31:0]), 64'hABCD_12CD);
      // R6: word 1 halves
      send(16'h0077, 16, 1'b0);
      send(16'h1355, 16, 1'b0); send(16'h1266, 16, 1'b0); settle(); check_all("R6");
      chk("R6", 64'(tune_o[63:32]), 64'h5577_6677);
      // R7: phase keeps low 12 bits
      send(16'h00FF, 16, 1'b0); send(16'h15FF, 16, 1'b1); settle(); check_all("R7");
      chk("R7", 64'(phase_o[23:12]), 64'hFFF);
      send(16'h1734, 16, 1'b0); settle(); check_all("R7");
      // R8: unused address and opcodes
      send(16'h19AA, 16, 1'b0); send(16'h5011, 16, 1'b0); send(16'h2312, 16, 1'b0);
      settle(); check_all("R8");
      // R3: short frames discarded, then a full frame still lands
      send(16'h1099, 10, 1'b0); send(16'h0044, 15, 1'b0); settle(); check_all("R3");
      send(16'h1088, 16, 1'b0); settle(); check_all("R3");
      // R2: overlong frame uses the first 16 bits
      send(16'h1143, 21, 1'b0); settle(); check_all("R2");
      // R9 R10 R11: register source ignores pins
      send(16'hC013, 16, 1'b0); send(16'hB000, 16, 1'b0); settle(); check_all("R9");
      chk("R10", 64'({freq_sel_o, phase_sel_o}), 64'h7);
      fpin = 1'b0; ppin = 2'b00; settle(); check_all("R11");
      send(16'hC002, 16, 1'b0); settle(); check_all("R10");
      fpin = 1'b1; ppin = 2'b01; settle(); check_all("R11");
      // R11: back to pin source
      send(16'h8FFF, 16, 1'b0); settle(); check_all("R9");
      fpin = 1'b0; ppin = 2'b11; settle(); check_all("R11");
      fpin = 1'b1; ppin = 2'b10; settle(); check_all("R11");

      // constrained random mix
      for (int n = 0; n < 250; n++) begin
         logic [15:0] w;
         int          kind, len;
         kind = int'($urandom % 10);
         w    = 16'($urandom);
         if (kind < 3)       w[15:12] = 4'h0;
         else if (kind < 7)  w[15:12] = 4'h1;
         else if (kind == 7) w[15:14] = 2'b10;
         else if (kind == 8) w[15:14] = 2'b11;
         len = ($urandom % 8 == 0) ? int'($urandom % 22) + 1 : 16;
         fpin = 1'($urandom);
         ppin = 2'($urandom);
         send(w, len, 1'b0);
         settle();
         check_all(len < 16 ? "R3" : (kind < 7 ? "R5" : "R11"));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule